// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches over the software running on a chip. A 7-bit down-counter counts toward a threshold. A free-running prescaler divides the system clock so that the counter loses one count every 2^PRESC_W cycles. Software must rewrite the counter before its top bit drops. A write that arrives too soon is rejected: the rewrite only counts when the counter has already fallen to or below a programmable window value. A refresh that is too late, too early or loads a value with the top bit clear produces a one-cycle reset request. When that request fires, the block also returns its own state to its power-on values.

Software reaches the block through a two-register write/read port that is one byte wide. Register 0 holds the activation bit and the counter. Register 1 holds the window value. Software can turn the activation bit on but can never turn it off. A strap input keeps the watchdog running no matter what that bit holds. A halt input freezes both the prescaler and the counter while the system sleeps.

Top module: `win_watchdog`

## Requirements
- R1: After reset, register 0 reads 7Fh, register 1 reads 7Fh and `wdog_req_o` is low.
- R2: `reg_sel_i` = 0 selects the control register: bit 7 is the activation bit and bits 6:0 are the counter. `reg_sel_i` = 1 selects the window register: writes store bits 6:0, and bit 7 always reads 0.
- R3: Writing 1 to bit 7 of register 0 sets the activation bit. Writing 0 to it never clears it. Only a reset request or `rst_ni` clears it.
- R4: While `hw_force_i` is low and the activation bit is 0, the counter does not move and no reset request is raised.
- R5: While active and not halted, the counter loses exactly one count every 2^PRESC_W clock cycles, counted from the last refresh or reset.
- R6: When the counter steps down from 40h while active, `wdog_req_o` goes high in the next cycle. With PRESC_W = 3, this is 513 edges after an enabling write.
- R7: A register-0 write while active and with counter > window raises `wdog_req_o` instead of loading the counter.
- R8: A register-0 write while active and with counter ≤ window loads bits 6:0 of the data and restarts the prescaler. No request is raised.
- R9: A register-0 write that leaves the watchdog active and loads a counter value with bit 6 clear raises `wdog_req_o`.
- R10: With `hw_force_i` high, the counter runs and expires even with the activation bit at 0. With PRESC_W = 3, the first request comes 512 edges after reset release.
- R11: While `halt_i` is high, the prescaler and the counter hold their values.
- R12: `wdog_req_o` is a single-cycle pulse. In the cycle it is high, the counter and the window read 7Fh and the activation bit reads 0.
- R13: When a valid register-0 write and a prescaler wrap fall in the same cycle, the written value wins and no decrement is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_force_i | input | 1 | Strap that keeps the watchdog permanently active |
| halt_i | input | 1 | Freezes the prescaler and the counter |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 window |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data of the selected register |
| wdog_req_o | output | 1 | One-cycle reset request |

## Verification
The bench sweeps every legal window value. For each one it refreshes exactly at the window edge and one count above it. A design that uses a strict comparison, or compares against the wrong operand, therefore trips or lets a refresh through at the wrong step. It measures the exact edge count from an enabling write, and from reset release under the strap, to the request. An off-by-one in the prescaler wrap or in the 40h threshold shifts that count. It also aims a refresh at the very cycle of a prescaler wrap, holds halt across many wraps, writes 0 to the activation bit, and loads a value with bit 6 clear. These catch a lost write, a counter that creeps during sleep, a bit software can clear, and a missing bad-load trip.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

   // register select decoding on the access port
   typedef enum logic [0:0] {
      REG_CTRL = 1'b0,
      REG_WIN  = 1'b1
   } wwd_reg_e;

   // reasons a reset request can be raised in a cycle
   typedef struct packed {
      logic early;
      logic low_load;
      logic expire;
   } wwd_cause_t;

endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler #(
   parameter int unsigned PRESC_W = 14
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic halt_i,
   input  logic clear_i,
   output logic tick_o
);

   generate
      if (PRESC_W == 0) begin : g_direct
         // no division: one step per running cycle
         assign tick_o = !halt_i;
      end else begin : g_count
         localparam logic [PRESC_W-1:0] PMAX = '1;
         logic [PRESC_W-1:0] pre_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)       pre_q <= '0;
            else if (clear_i)  pre_q <= '0;
            else if (!halt_i)  pre_q <= pre_q + 1'b1;
         end

         assign tick_o = !halt_i && (pre_q == PMAX);

         // R11: a halted prescaler keeps its count
         a_r11_presc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
            halt_i && !clear_i |=> $stable(pre_q));
      end
   endgenerate

endmodule

// File: rtl/wwd_downcounter.sv
module wwd_downcounter #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restore_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             step_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);

   localparam logic [CNT_W-1:0] CNT_RST = '1;
   localparam logic [CNT_W-1:0] THRESH  = {1'b1, {(CNT_W-1){1'b0}}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cnt_q <= CNT_RST;
      else if (restore_i)  cnt_q <= CNT_RST;
      else if (load_i)     cnt_q <= load_val_i;
      else if (step_i)     cnt_q <= cnt_q - 1'b1;
   end

   // the step that would clear the top bit
   assign expire_o = step_i && (cnt_q == THRESH);
   assign cnt_o    = cnt_q;

   // R4: without a step, load or restore the count is unchanged
   a_r4_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step_i && !load_i && !restore_i |=> $stable(cnt_q));

endmodule

// File: rtl/wwd_regs.sv
module wwd_regs
   import wwd_pkg::*;
#(
   parameter int unsigned CNT_W  = 7,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              restore_i,
   input  logic              win_we_i,
   input  logic              act_set_i,
   input  logic [CNT_W-1:0]  win_wdata_i,
   input  wwd_reg_e          rd_sel_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              act_o,
   output logic [CNT_W-1:0]  win_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam logic [CNT_W-1:0] WIN_RST = '1;

   logic             act_q;
   logic [CNT_W-1:0] win_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         act_q <= 1'b0;
      else if (restore_i)  act_q <= 1'b0;
      else if (act_set_i)  act_q <= 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         win_q <= WIN_RST;
      else if (restore_i)  win_q <= WIN_RST;
      else if (win_we_i)   win_q <= win_wdata_i;
   end

   always_comb begin
      rdata_o = '0;
      if (rd_sel_i == REG_CTRL) begin
         rdata_o[CNT_W]     = act_q;
         rdata_o[CNT_W-1:0] = cnt_i;
      end else begin
         rdata_o[CNT_W-1:0] = win_q;
      end
   end

   assign act_o = act_q;
   assign win_o = win_q;

   // R3: software has no way to clear the activation bit
   a_r3_act_one_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_q && !restore_i |=> act_q);

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
   import wwd_pkg::*;
#(
   parameter int unsigned CNT_W   = 7,
   parameter int unsigned PRESC_W = 14,
   parameter int unsigned DATA_W  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              hw_force_i,
   input  logic              halt_i,
   input  logic              reg_we_i,
   input  logic              reg_sel_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              wdog_req_o
);

   localparam int unsigned     ACT_BIT = CNT_W;
   localparam int unsigned     TOP_BIT = CNT_W - 1;
   localparam logic [CNT_W-1:0] THRESH = {1'b1, {(CNT_W-1){1'b0}}};

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("win_watchdog: CNT_W must be at least 2");
      end
      if (DATA_W < CNT_W + 1) begin : g_bad_data
         $error("win_watchdog: DATA_W must hold the counter plus the activation bit");
      end
   endgenerate

   wwd_reg_e         sel;
   logic             ctrl_wr, win_wr;
   logic             act_q, active, arm_after;
   logic [CNT_W-1:0] cnt_q, win_q;
   logic             tick, step, expire, trip, load, act_set;
   wwd_cause_t       cause;
   logic             req_q;

   assign sel       = wwd_reg_e'(reg_sel_i);
   assign ctrl_wr   = reg_we_i && (sel == REG_CTRL);
   assign win_wr    = reg_we_i && (sel == REG_WIN);
   assign active    = hw_force_i || act_q;
   assign arm_after = active || reg_wdata_i[ACT_BIT];

   // refresh before the window opens
   assign cause.early    = ctrl_wr && active && (cnt_q > win_q);
   // refresh that would leave an already-expired count
   assign cause.low_load = ctrl_wr && !cause.early && arm_after && !reg_wdata_i[TOP_BIT];
   assign cause.expire   = expire;
   assign trip           = |cause;

   // a write in the same cycle as a prescaler wrap takes precedence
   assign step    = tick && active && !ctrl_wr;
   assign load    = ctrl_wr && !trip;
   assign act_set = load && reg_wdata_i[ACT_BIT];

   wwd_prescaler #(.PRESC_W(PRESC_W)) u_presc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .halt_i  (halt_i),
      .clear_i (load || trip),
      .tick_o  (tick)
   );

   wwd_downcounter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .restore_i  (trip),
      .load_i     (load),
      .load_val_i (reg_wdata_i[CNT_W-1:0]),
      .step_i     (step),
      .cnt_o      (cnt_q),
      .expire_o   (expire)
   );

   wwd_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .restore_i   (trip),
      .win_we_i    (win_wr),
      .act_set_i   (act_set),
      .win_wdata_i (reg_wdata_i[CNT_W-1:0]),
      .rd_sel_i    (sel),
      .cnt_i       (cnt_q),
      .act_o       (act_q),
      .win_o       (win_q),
      .rdata_o     (reg_rdata_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q <= 1'b0;
      else         req_q <= trip;
   end

   assign wdog_req_o = req_q;

   // R6: stepping down from the threshold raises a request next cycle
   a_r6_expire_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick && active && !reg_we_i && (cnt_q == THRESH) |=> wdog_req_o);

   // R7: a refresh above the window is punished, not loaded
   a_r7_early_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_wr && active && (cnt_q > win_q) |=> wdog_req_o);

   // R8: an in-window refresh with the top bit set loads the data quietly
   a_r8_valid_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_wr && active && (cnt_q <= win_q) && reg_wdata_i[TOP_BIT]
      |=> !wdog_req_o && (cnt_q == $past(reg_wdata_i[CNT_W-1:0])));

   // R12: the request cycle shows all state back at its reset values
   a_r12_restored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wdog_req_o |-> (cnt_q == '1) && (win_q == '1) && !act_q);

   // R10: under the strap the counter steps even with the activation bit clear
   a_r10_strap_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hw_force_i && !act_q && tick && !reg_we_i && (cnt_q != THRESH)
      |=> cnt_q == $past(cnt_q) - 1'b1);

   // R4: idle and disabled means no request
   a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hw_force_i && !act_q && !reg_we_i |=> !wdog_req_o);

endmodule

// File: tb/test_win_watchdog.sv
module test_win_watchdog;

   localparam int CW = 7;
   localparam int PW = 3;
   localparam int DW = 8;
   localparam int PERIOD_TICKS = 1 << PW;
   localparam int EXPIRE_EDGES = (1 << (CW - 1)) * PERIOD_TICKS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hw = 1'b0;
   logic          halt = 1'b0;
   logic          we = 1'b0;
   logic          sel = 1'b0;
   logic [DW-1:0] wd = '0;
   logic [DW-1:0] rd;
   logic          req;

   // 20 ns period: 50 MHz
   always #10 clk = ~clk;

   win_watchdog #(.CNT_W(CW), .PRESC_W(PW), .DATA_W(DW)) i_win_watchdog (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .hw_force_i  (hw),
      .halt_i      (halt),
      .reg_we_i    (we),
      .reg_sel_i   (sel),
      .reg_wdata_i (wd),
      .reg_rdata_o (rd),
      .wdog_req_o  (req)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // behavioural reference built from the requirements
   int        m_pre = 0;
   logic [6:0] m_cnt = 7'h7f;
   logic [6:0] m_win = 7'h7f;
   logic      m_act = 1'b0;
   logic      m_req = 1'b0;
   logic      m_active, m_cw, m_ww, m_tick, m_early, m_low, m_exp, m_trip;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0; m_cnt = 7'h7f; m_win = 7'h7f; m_act = 1'b0; m_req = 1'b0;
      end else begin
         m_active = hw | m_act;
         m_cw     = we & !sel;
         m_ww     = we & sel;
         m_tick   = !halt && (m_pre == PERIOD_TICKS - 1);
         m_early  = m_cw && m_active && (m_cnt > m_win);
         m_low    = m_cw && !m_early && (m_active || wd[7]) && !wd[6];
         m_exp    = m_active && m_tick && !m_cw && (m_cnt == 7'h40);
         m_trip   = m_early || m_low || m_exp;
         m_req    = m_trip;
         if (m_trip) begin
            m_pre = 0; m_cnt = 7'h7f; m_win = 7'h7f; m_act = 1'b0;
         end else begin
            if (m_cw) begin
               m_cnt = wd[6:0];
               m_act = m_act | wd[7];
               m_pre = 0;
            end else begin
               if (m_tick && m_active) m_cnt = m_cnt - 7'd1;
               if (!halt) m_pre = (m_pre + 1) % PERIOD_TICKS;
            end
            if (m_ww) m_win = wd[6:0];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   // compare both registers and the request against the reference
   task automatic sample(input string tag);
      @(negedge clk);
      we = 1'b0;
      sel = 1'b0; #1;
      chk(tag, 32'(rd), 32'({m_act, m_cnt}));
      sel = 1'b1; #1;
      chk(tag, 32'(rd), 32'({1'b0, m_win}));
      chk(tag, 32'(req), 32'(m_req));
   endtask

   task automatic peek(input logic s, input logic [7:0] exp, input string tag);
      sel = s; #1;
      chk(tag, 32'(rd), 32'(exp));
   endtask

   task automatic drive(input logic w, input logic s, input logic [7:0] d);
      we = w; sel = s; wd = d;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         sample(tag);
         drive(1'b0, 1'b0, 8'h00);
      end
   endtask

   // returns right after the sample in which the counter equals target
   task automatic wait_cnt(input logic [6:0] target, input string tag);
      int g = 0;
      sample(tag);
      while (m_cnt != target && g < 2000) begin
         drive(1'b0, 1'b0, 8'h00);
         sample(tag);
         g++;
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      sample("R1");
      peek(1'b0, 8'h7f, "R1");
      peek(1'b1, 8'h7f, "R1");
      chk("R1", 32'(req), 0);
      drive(1'b0, 1'b0, 8'h00);

      // R4 disabled: nothing moves over many prescaler periods
      idle(700, "R4");
      sample("R4");
      peek(1'b0, 8'h7f, "R4");
      drive(1'b0, 1'b0, 8'h00);

      // R2 window register: bit 7 is reserved
      sample("R2");
      drive(1'b1, 1'b1, 8'hD5);
      sample("R2");
      peek(1'b1, 8'h55, "R2");
      drive(1'b1, 1'b1, 8'hFF);
      sample("R2");
      peek(1'b1, 8'h7f, "R2");
      peek(1'b0, 8'h7f, "R2");
      drive(1'b0, 1'b0, 8'h00);

      // R6 exact expiry distance from an enabling write
      sample("R6");
      drive(1'b1, 1'b0, 8'hFF);
      k = 0;
      do begin
         sample("R6");
         drive(1'b0, 1'b0, 8'h00);
         k++;
      end while (!req && k < 2000);
      chk("R6", 32'(k), 32'(EXPIRE_EDGES + 1));

      // R12 single pulse, state restored
      sample("R12");
      chk("R12", 32'(req), 0);
      peek(1'b0, 8'h7f, "R12");
      drive(1'b0, 1'b0, 8'h00);

      // R5 step rate: five prescaler periods after enabling
      sample("R5");
      drive(1'b1, 1'b0, 8'hFF);
      idle(5 * PERIOD_TICKS, "R5");
      sample("R5");
      peek(1'b0, 8'hFA, "R5");

      // R3 writing 0 to the activation bit leaves it set
      drive(1'b1, 1'b0, 8'h7F);
      sample("R3");
      peek(1'b0, 8'hFF, "R3");
      drive(1'b0, 1'b0, 8'h00);

      // R13 refresh lands on the wrap cycle
      sample("R13");
      while (m_pre != PERIOD_TICKS - 1) begin
         drive(1'b0, 1'b0, 8'h00);
         sample("R13");
      end
      drive(1'b1, 1'b0, 8'hF3);
      sample("R13");
      peek(1'b0, 8'hF3, "R13");
      drive(1'b0, 1'b0, 8'h00);

      // R11 halt freezes the count across many wraps
      halt = 1'b1;
      idle(100, "R11");
      sample("R11");
      peek(1'b0, 8'hF3, "R11");
      halt = 1'b0;
      drive(1'b0, 1'b0, 8'h00);

      // R9 in-window load with bit 6 clear
      sample("R9");
      drive(1'b1, 1'b0, 8'hBF);
      sample("R9");
      chk("R9", 32'(req), 1);
      peek(1'b0, 8'h7f, "R9");
      drive(1'b0, 1'b0, 8'h00);

      // R10 strap: expires with the activation bit clear
      sample("R10");
      hw = 1'b1;
      rst_n = 1'b0;
      sample("R10");
      rst_n = 1'b1;
      drive(1'b0, 1'b0, 8'h00);
      k = 0;
      do begin
         sample("R10");
         drive(1'b0, 1'b0, 8'h00);
         k++;
      end while (!req && k < 2000);
      chk("R10", 32'(k), 32'(EXPIRE_EDGES));
      sample("R10");
      peek(1'b0, 8'h7f, "R10");
      hw = 1'b0;
      drive(1'b0, 1'b0, 8'h00);

      // R7 / R8 sweep over every window value
      for (int w = 64; w < 128; w++) begin
         // in-window refresh at the edge of the window
         sample("R8");
         drive(1'b1, 1'b1, 8'(w));
         sample("R8");
         drive(1'b1, 1'b0, 8'hFF);
         wait_cnt(7'(w), "R8");
         drive(1'b1, 1'b0, 8'hFF);
         sample("R8");
         chk("R8", 32'(req), 0);
         peek(1'b0, 8'hFF, "R8");
         // bring the block back with a forced trip
         drive(1'b1, 1'b0, 8'h00);
         sample("R9");
         chk("R9", 32'(req), 1);
         drive(1'b0, 1'b0, 8'h00);
         if (w < 127) begin
            // one count above the window
            sample("R7");
            drive(1'b1, 1'b1, 8'(w));
            sample("R7");
            drive(1'b1, 1'b0, 8'hFF);
            wait_cnt(7'(w + 1), "R7");
            drive(1'b1, 1'b0, 8'hFF);
            sample("R7");
            chk("R7", 32'(req), 1);
            peek(1'b0, 8'h7f, "R7");
            peek(1'b1, 8'h7f, "R7");
            drive(1'b0, 1'b0, 8'h00);
         end
      end

      idle(4, "R12");
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, got hung expected done");
         summary();
         $finish;
      end
   end

endmodule